// File: doc/BRIEF.md
# Interrupt Status Aggregator with Per-Source Set and Clear Rules

This block gathers six interrupt sources into one status vector and a single interrupt request line. Each source has its own rule for setting and clearing. Three sources follow external pins. Two of those pins are active low and one is active high. Each pin passes through a two-flop synchronizer, and its status bit tracks the pin level. The other three sources are sticky flags: a codec FIFO threshold event and the underflow of two down-counting timers. Each sticky flag is cleared by its own one-cycle strobe, which the bus logic decodes from an end-of-interrupt write.

The codec flag captures the rising edge of one of two FIFO conditions. The transfer direction picks which one: the half-full condition when receiving, the empty condition when transmitting. A timer flag does not set the moment its counter reaches zero. The zero indication arms the flag, and the flag sets on the first falling edge of that timer's clock seen after arming. A mask register, written in one cycle, chooses which status bits drive the request line. The timers, the FIFO and the bus decoding sit outside this block. Timer clocks, zero indications and FIFO conditions arrive synchronous to `clk`.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is held, and after its release, `status_o` is 0 and `irq_o` is 0. The mask register resets to all zeros, so no status bit reaches `irq_o` until the mask is written.
- R2: Status bits 0 and 1 are 1 while `ext_low_n_i[0]` and `ext_low_n_i[1]` are low, and 0 while they are high. A pin change shows on the status bit two `clk` rising edges after it is driven, not one.
- R3: Status bit 2 equals `ext_high_i` as it was two `clk` rising edges earlier.
- R4: Status bit 3 (codec) sets on the cycle after a rising edge of the selected condition. `codec_dir_i`=0 selects `codec_half_full_i` and `codec_dir_i`=1 selects `codec_empty_i`. The unselected condition has no effect. Once set, the bit stays set with no clear strobe.
- R5: A pulse on `clr_i[3]` clears status bit 3 in the next cycle. A selected condition that stays high does not set the bit again.
- R6: A pulse on `tmr_zero_i[t]` arms timer t. Status bit 4+t sets in the cycle after the first cycle in which `tmr_clk_i[t]` is seen 0 after having been 1, counting only such falling edges that come strictly after the arming cycle. A falling edge with no arming, or a second falling edge after the flag has set, leaves the bit unchanged.
- R7: A pulse on `clr_i[4+t]` clears status bit 4+t in the next cycle and leaves the other timer's bit unchanged. Once set, the bit holds until that strobe arrives.
- R8: When a set event and the clear strobe of the same sticky source come in one cycle, the bit is 1 afterwards.
- R9: `clr_i[2:0]` has no effect on the pin-following status bits.
- R10: `irq_o` is the OR over i of `status_o[i]` AND `mask[i]`. A cycle with `mask_we_i`=1 loads `mask_wdata_i`, and `irq_o` reflects the new mask in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_low_n_i | input | 2 | Active-low external interrupt pins (asynchronous) |
| ext_high_i | input | 1 | Active-high external interrupt pin (asynchronous) |
| codec_dir_i | input | 1 | Codec transfer direction: 0 receive, 1 transmit |
| codec_half_full_i | input | 1 | Codec FIFO half-full condition |
| codec_empty_i | input | 1 | Codec FIFO empty condition |
| tmr_clk_i | input | 2 | Per-timer clock level, sampled by `clk` |
| tmr_zero_i | input | 2 | Per-timer count-reached-zero indication |
| clr_i | input | 6 | Per-source end-of-interrupt clear strobes |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 6 | Mask register write data |
| status_o | output | 6 | Interrupt status vector |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench sweeps every combination of the three pins while hammering their clear strobes. It samples one edge early and again on time. A design with one synchronizer stage too few or too many, an inverted polarity, or a latch on a level source fails the sweep. The codec and timer tests target the edge cases: a persisting condition after a clear, the unselected FIFO condition, a falling edge in the same cycle as arming, arming followed by falling edges 1 to 4 cycles later, a second falling edge with no re-arm, and set and clear in the same cycle. A flag that sets on the zero indication itself, re-fires on a held level, or lets a clear win would show the wrong status. A sweep of all 64 masks against eight status patterns catches a wrong mask bit, an AND written as OR, and a mask that resets open.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic {
    CODEC_DIR_RX = 1'b0,
    CODEC_DIR_TX = 1'b1
  } codec_dir_e;

  function automatic int unsigned src_total(input int unsigned n_low,
                                            input int unsigned n_high,
                                            input int unsigned n_tmr);
    return n_low + n_high + 1 + n_tmr;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = pipe_q[STAGES-1];

endmodule

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= RST_VAL;
      end
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_codec_evt.sv
module irq_codec_evt
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic half_full_i,
  input  logic empty_i,
  output logic set_o
);

  codec_dir_e dir;
  logic       sel;
  logic       sel_prev_q;
  logic       sel_prev_d;

  assign dir = codec_dir_e'(dir_i);

  always_comb begin
    unique case (dir)
      CODEC_DIR_TX: sel = empty_i;
      default:      sel = half_full_i;
    endcase
    sel_prev_d = sel;
    set_o      = sel & ~sel_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q <= 1'b0;
    end else begin
      sel_prev_q <= sel_prev_d;
    end
  end

endmodule

// File: rtl/irq_tmr_align.sv
module irq_tmr_align #(
  parameter int unsigned NUM_TMR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TMR-1:0] tmr_clk_i,
  input  logic [NUM_TMR-1:0] zero_i,
  output logic [NUM_TMR-1:0] set_o
);

  logic [NUM_TMR-1:0] clk_prev_q;
  logic [NUM_TMR-1:0] arm_q;
  logic [NUM_TMR-1:0] arm_d;
  logic [NUM_TMR-1:0] fall;

  always_comb begin
    fall  = clk_prev_q & ~tmr_clk_i;
    set_o = fall & arm_q;
    arm_d = zero_i | (arm_q & ~fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= '0;
      arm_q      <= '0;
    end else begin
      clk_prev_q <= tmr_clk_i;
      arm_q      <= arm_d;
    end
  end

endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);

  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_d;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_LOW     = 2,
  parameter int unsigned NUM_HIGH    = 1,
  parameter int unsigned NUM_TMR     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_SRC    = src_total(NUM_LOW, NUM_HIGH, NUM_TMR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOW-1:0] ext_low_n_i,
  input  logic [NUM_HIGH-1:0] ext_high_i,
  input  logic               codec_dir_i,
  input  logic               codec_half_full_i,
  input  logic               codec_empty_i,
  input  logic [NUM_TMR-1:0] tmr_clk_i,
  input  logic [NUM_TMR-1:0] tmr_zero_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o
);

  localparam int unsigned CODEC_BIT  = NUM_LOW + NUM_HIGH;
  localparam int unsigned NUM_STICKY = 1 + NUM_TMR;

  logic                  rst_sync_n;
  logic [NUM_LOW-1:0]    low_sync_n;
  logic [NUM_HIGH-1:0]   high_sync;
  logic                  codec_set;
  logic [NUM_TMR-1:0]    tmr_set;
  logic [NUM_STICKY-1:0] sticky_set;
  logic [NUM_STICKY-1:0] sticky_clr;
  logic [NUM_STICKY-1:0] sticky_flag;
  logic [NUM_SRC-1:0]    mask_q;
  logic [NUM_SRC-1:0]    mask_d;
  logic                  unused_lvl_clr;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  irq_sync_bank #(
    .WIDTH   (NUM_LOW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({NUM_LOW{1'b1}})
  ) u_sync_low (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (ext_low_n_i),
    .sync_o  (low_sync_n)
  );

  irq_sync_bank #(
    .WIDTH   (NUM_HIGH),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({NUM_HIGH{1'b0}})
  ) u_sync_high (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (ext_high_i),
    .sync_o  (high_sync)
  );

  irq_codec_evt u_codec_evt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .dir_i       (codec_dir_i),
    .half_full_i (codec_half_full_i),
    .empty_i     (codec_empty_i),
    .set_o       (codec_set)
  );

  irq_tmr_align #(.NUM_TMR(NUM_TMR)) u_tmr_align (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tmr_clk_i (tmr_clk_i),
    .zero_i    (tmr_zero_i),
    .set_o     (tmr_set)
  );

  // Sticky group: codec at its LSB, timers above.
  assign sticky_set = {tmr_set, codec_set};
  assign sticky_clr = clr_i[NUM_SRC-1:CODEC_BIT];

  irq_sticky_flag #(.WIDTH(NUM_STICKY)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (sticky_set),
    .clr_i  (sticky_clr),
    .flag_o (sticky_flag)
  );

  // Level sources have no latch; their strobes go nowhere.
  assign unused_lvl_clr = ^clr_i[CODEC_BIT-1:0];

  always_comb begin
    mask_d = mask_q;
    if (mask_we_i) begin
      mask_d = mask_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  assign status_o = {sticky_flag, high_sync, ~low_sync_n};
  assign irq_o    = |(status_o & mask_q);

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
  parameter int unsigned NUM_LOW  = 2,
  parameter int unsigned NUM_HIGH = 1,
  parameter int unsigned NUM_TMR  = 2,
  parameter int unsigned NUM_SRC  = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_LOW-1:0]  ext_low_n_i,
  input logic [NUM_HIGH-1:0] ext_high_i,
  input logic                codec_half_full_i,
  input logic                codec_empty_i,
  input logic [NUM_TMR-1:0]  tmr_clk_i,
  input logic [NUM_SRC-1:0]  clr_i,
  input logic [NUM_SRC-1:0]  status_o,
  input logic                irq_o
);

  localparam int unsigned CB = NUM_LOW + NUM_HIGH;
  localparam int unsigned TB = CB + 1;

  logic [1:0] warm_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != 2'd3) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  assign warm = (warm_q == 2'd3);

  for (genvar i = 0; i < NUM_LOW; i++) begin : g_low
    // R2 and R9: level follows pin after two edges, whatever the strobes do.
    p_low_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (status_o[i] == !$past(ext_low_n_i[i], 2)));
  end

  for (genvar i = 0; i < NUM_HIGH; i++) begin : g_high
    p_high_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (status_o[NUM_LOW+i] == $past(ext_high_i[i], 2)));
  end

  p_codec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o[CB]) && !$past(clr_i[CB])) |-> status_o[CB]);

  p_codec_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o[CB]) && $past(clr_i[CB]) &&
     !$past(codec_half_full_i) && !$past(codec_empty_i)) |-> !status_o[CB]);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    p_tmr_fall_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $rose(status_o[TB+t])) |->
        ($past(tmr_clk_i[t], 2) && !$past(tmr_clk_i[t])));

    p_tmr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_o[TB+t]) && !$past(clr_i[TB+t])) |-> status_o[TB+t]);
  end

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == '0) |-> !irq_o);

endmodule

bind irq_status_agg irq_status_agg_chk #(
  .NUM_LOW  (NUM_LOW),
  .NUM_HIGH (NUM_HIGH),
  .NUM_TMR  (NUM_TMR),
  .NUM_SRC  (NUM_SRC)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_sync_n),
  .ext_low_n_i       (ext_low_n_i),
  .ext_high_i        (ext_high_i),
  .codec_half_full_i (codec_half_full_i),
  .codec_empty_i     (codec_empty_i),
  .tmr_clk_i         (tmr_clk_i),
  .clr_i             (clr_i),
  .status_o          (status_o),
  .irq_o             (irq_o)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;
  localparam int CB = 3;
  localparam int TB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    ext_low_n;
  logic [0:0]    ext_high;
  logic          codec_dir;
  logic          half_full;
  logic          empty;
  logic [1:0]    tmr_clk;
  logic [1:0]    tmr_zero;
  logic [NS-1:0] clr;
  logic          mask_we;
  logic [NS-1:0] mask_wdata;
  logic [NS-1:0] status;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .ext_low_n_i       (ext_low_n),
    .ext_high_i        (ext_high),
    .codec_dir_i       (codec_dir),
    .codec_half_full_i (half_full),
    .codec_empty_i     (empty),
    .tmr_clk_i         (tmr_clk),
    .tmr_zero_i        (tmr_zero),
    .clr_i             (clr),
    .mask_we_i         (mask_we),
    .mask_wdata_i      (mask_wdata),
    .status_o          (status),
    .irq_o             (irq)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_mask(input logic [NS-1:0] m);
    mask_we    = 1'b1;
    mask_wdata = m;
    tick();
    mask_we    = 1'b0;
  endtask

  task automatic set_pins(input logic [2:0] v);
    ext_low_n = ~v[1:0];
    ext_high  = v[2];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_low_n = 2'b11; ext_high = 1'b0; codec_dir = 1'b0;
    half_full = 1'b0; empty = 1'b0; tmr_clk = 2'b11; tmr_zero = 2'b00;
    clr = '0; mask_we = 1'b0; mask_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 status in reset", 32'(status), 0);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 status after reset", 32'(status), 0);
    chk("R1 irq after reset", 32'(irq), 0);

    // Pin sweep with level strobes held (R2, R3, R9); mask still at reset value (R1).
    begin
      logic [2:0] prev;
      prev = 3'd0;
      for (int v = 0; v < 8; v++) begin
        set_pins(3'(v));
        clr = 6'b000111;
        tick();
        chk("R2/R3 one edge: old level still shown", 32'(status[2:0]), 32'(prev));
        tick();
        chk("R2/R3/R9 two edges: pin level shown", 32'(status[2:0]), 32'(v));
        chk("R1 closed mask keeps irq low", 32'(irq), 0);
        prev = 3'(v);
      end
      clr = '0;
    end

    // Mask sweep over pin-driven status patterns (R10).
    for (int p = 0; p < 8; p++) begin
      set_pins(3'(p));
      tick(2);
      for (int m = 0; m < 64; m++) begin
        write_mask(6'(m));
        chk("R10 irq = OR(status & mask)", 32'(irq), 32'(|(3'(p) & 3'(m))));
      end
    end
    set_pins(3'd0);
    tick(2);
    write_mask(6'b111000);

    // Codec (R4, R5, R8).
    codec_dir = 1'b0;
    empty = 1'b1; tick();
    chk("R4 rx: empty ignored", 32'(status[CB]), 0);
    empty = 1'b0;
    half_full = 1'b1; tick();
    chk("R4 rx: half-full edge sets", 32'(status[CB]), 1);
    chk("R10 codec drives irq", 32'(irq), 1);
    tick(3);
    chk("R4 flag holds", 32'(status[CB]), 1);
    clr[CB] = 1'b1; tick(); clr[CB] = 1'b0;
    chk("R5 clear strobe clears", 32'(status[CB]), 0);
    tick(2);
    chk("R5 held condition does not re-set", 32'(status[CB]), 0);
    half_full = 1'b0; tick();
    codec_dir = 1'b1;
    half_full = 1'b1; tick();
    chk("R4 tx: half-full ignored", 32'(status[CB]), 0);
    half_full = 1'b0;
    empty = 1'b1; tick();
    chk("R4 tx: empty edge sets", 32'(status[CB]), 1);
    empty = 1'b0; tick();
    empty = 1'b1; clr[CB] = 1'b1; tick(); clr[CB] = 1'b0;
    chk("R8 codec set beats clear", 32'(status[CB]), 1);
    empty = 1'b0;
    clr[CB] = 1'b1; tick(); clr[CB] = 1'b0;
    chk("R5 clear after collision", 32'(status[CB]), 0);
    codec_dir = 1'b0; tick();

    // Timers (R6, R7, R8).
    for (int t = 0; t < 2; t++) begin
      tmr_clk[t] = 1'b0; tick();
      chk("R6 fall without arm ignored", 32'(status[TB+t]), 0);
      tmr_clk[t] = 1'b1; tick();

      for (int d = 1; d <= 4; d++) begin
        tmr_zero[t] = 1'b1; tick(); tmr_zero[t] = 1'b0;
        chk("R6 zero alone does not set", 32'(status[TB+t]), 0);
        for (int k = 1; k < d; k++) begin
          tick();
          chk("R6 waits for falling edge", 32'(status[TB+t]), 0);
        end
        tmr_clk[t] = 1'b0; tick();
        chk("R6 sets after falling edge", 32'(status[TB+t]), 1);
        chk("R7 other timer untouched", 32'(status[TB+1-t]), 0);
        tmr_clk[t] = 1'b1; tick();
        tmr_clk[t] = 1'b0; tick();
        chk("R7 flag holds over next edge", 32'(status[TB+t]), 1);
        tmr_clk[t] = 1'b1;
        clr[TB+t] = 1'b1; tick(); clr[TB+t] = 1'b0;
        chk("R7 clear strobe clears", 32'(status[TB+t]), 0);
        tmr_clk[t] = 1'b0; tick();
        chk("R6 no re-set without re-arm", 32'(status[TB+t]), 0);
        tmr_clk[t] = 1'b1; tick();
      end

      // Falling edge in the arming cycle itself does not count.
      tmr_zero[t] = 1'b1; tmr_clk[t] = 1'b0; tick(); tmr_zero[t] = 1'b0;
      chk("R6 fall in arming cycle ignored", 32'(status[TB+t]), 0);
      tmr_clk[t] = 1'b1; tick();
      chk("R6 still armed, not set", 32'(status[TB+t]), 0);
      tmr_clk[t] = 1'b0; tick();
      chk("R6 later fall sets", 32'(status[TB+t]), 1);
      tmr_clk[t] = 1'b1; tick();

      // Set and clear in one cycle.
      tmr_zero[t] = 1'b1; tick(); tmr_zero[t] = 1'b0;
      tmr_clk[t] = 1'b0; clr[TB+t] = 1'b1; tick(); clr[TB+t] = 1'b0;
      chk("R8 timer set beats clear", 32'(status[TB+t]), 1);
      chk("R10 timer drives irq", 32'(irq), 1);
      tmr_clk[t] = 1'b1;
      clr[TB+t] = 1'b1; tick(); clr[TB+t] = 1'b0;
      chk("R7 clear after collision", 32'(status[TB+t]), 0);
      chk("R10 irq drops", 32'(irq), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule